// File: doc/BRIEF.md
# Halfword Register-Offset Load Unit

This unit executes one load of a 16-bit value whose address is formed from two registers: a base and an index. It accepts an instruction word in one of three encodings, selected by a form input: a 32-bit conditional form, a 16-bit compact form and a 32-bit compact form. It decodes the word and reads the base and index through two register read ports. It shifts the index, then adds it to or subtracts it from the base. It issues a single halfword read over a valid/ready request channel, takes the reply over a valid/ready response channel, zero-extends it and writes the destination register. Where the encoding asks for it, the unit also writes the updated base back, through a second write port in the same cycle.

Words that belong to a neighbouring instruction are reported as redirects and are not executed. Register combinations that have no defined result are flagged. A failed condition turns the instruction into a no-op. The unit accepts an instruction only while idle (`ins_ready` high). It presents a request until memory takes it: `mem_req_valid` and `mem_req_addr` hold steady while `mem_req_ready` is low. It waits on the response with `mem_rsp_ready` high for as long as memory needs. Every instruction ends with a one-cycle `done` pulse that carries the outcome code and the unpredictable flag.

Top module: `hwl_load_unit`

## Requirements
- R1: Form encoding is 0 = 32-bit conditional, 1 = 16-bit compact (bits [15:0] only), 2 = 32-bit compact (first halfword in bits [31:16]), 3 = reserved. A reserved form, or a word whose fixed bits do not match, completes with outcome 6 (no match), one cycle after acceptance, with no memory access and no register write. Outcome codes are: 0 executed, 1 skipped, 2 unprivileged redirect, 3 literal redirect, 4 prefetch-for-write redirect, 5 undefined, 6 no match.
- R2: Conditional form fields and fixed bits. It requires [31:28] != 1111, [27:25] = 000, bit 22 = 0, bit 20 = 1 and [7:4] = 1011. Base is [19:16], destination is [15:12] and index is [3:0]. Bit 24 selects pre-indexing, bit 23 selects add (1) or subtract (0), and bit 21 together with bit 24 selects writeback. The index is not shifted.
- R3: In the conditional form, bit 24 = 0 together with bit 21 = 1 gives outcome 2 and is not executed.
- R4: The 16-bit form requires [15:9] = 0101101, with index [8:6], base [5:3] and destination [2:0] (registers 0 to 7). It always pre-indexes, always adds, uses no shift and never writes back.
- R5: The 32-bit compact form requires bits [31:20] = 111110000011, with base [19:16]. If the base is 1111 the outcome is 3. Otherwise, bits [11:6] must be zero (else outcome 6). If the destination [15:12] is 1111 the outcome is 4. Otherwise the index [3:0] is shifted left by bits [5:4], and the instruction adds, pre-indexes and does not write back.
- R6: The offset address is base plus or minus the shifted index, modulo 2^32. The read address is the offset address when pre-indexing, and the unmodified base otherwise.
- R7: The destination receives the returned halfword in bits [15:0] with bits [31:16] zero.
- R8: Writeback is set when bit 24 = 0 or bit 21 = 1. The base register is then written with the offset address in the same cycle as the destination. Without writeback, no base write occurs.
- R9: `done_unp` is high when any of these holds: the conditional form with destination 15, index 15 or bits [11:8] nonzero; the 32-bit compact form with index 15; writeback with base 15 or with base equal to destination.
- R10: Writeback with base equal to destination gives outcome 5 with no memory access and no register write.
- R11: With `ins_cond_pass` low, a matched non-redirected instruction completes with outcome 1 one cycle after acceptance, with no access and no write.
- R12: `ins_ready` is high only while idle. The request stays valid with a stable address until `mem_req_ready`, and exactly one request is made per executed instruction.
- R13: `done` is a single-cycle pulse that follows the register write cycle directly for executed instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle, instruction taken on valid |
| ins_form | input | 2 | Encoding select |
| ins_word | input | 32 | Instruction word |
| ins_cond_pass | input | 1 | Condition result for this instruction |
| rf_base_idx | output | 4 | Base register read index |
| rf_base_data | input | XLEN | Base register value |
| rf_offs_idx | output | 4 | Index register read index |
| rf_offs_data | input | XLEN | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | XLEN | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit accepts read data |
| mem_rsp_data | input | HALF_W | Returned halfword |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 4 | Destination register |
| dst_data | output | XLEN | Zero-extended load value |
| base_we | output | 1 | Base writeback enable |
| base_idx | output | 4 | Base register for writeback |
| base_data | output | XLEN | Updated base value |
| done | output | 1 | Completion pulse |
| done_res | output | 3 | Outcome code, valid with done |
| done_unp | output | 1 | Unpredictable flag, valid with done |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only after it has accepted a request, and lowers it once the response handshake has taken place. They also assume that the register read data settles combinationally from the read indices. The bench's memory model follows both rules. It grants the request after a varying number of stall cycles, answers only after a request has been taken, and derives the read data from the captured address. The register model is a fixed function of the index, so the read data is always a pure function of the index.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  localparam int RIDX_W = 4;
  localparam int SH_W   = 2;

  typedef enum logic [1:0] {
    FORM_C32 = 2'd0,
    FORM_N16 = 2'd1,
    FORM_W32 = 2'd2,
    FORM_RSV = 2'd3
  } form_e;

  typedef enum logic [2:0] {
    RES_EXEC      = 3'd0,
    RES_SKIP      = 3'd1,
    RES_TO_UNPRIV = 3'd2,
    RES_TO_LIT    = 3'd3,
    RES_TO_PFW    = 3'd4,
    RES_UNDEF     = 3'd5,
    RES_NOMATCH   = 3'd6
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_REQ  = 3'd2,
    S_WAIT = 3'd3,
    S_WB   = 3'd4,
    S_DONE = 3'd5
  } st_e;

  typedef struct packed {
    logic [2:0]        res;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rm;
    logic [SH_W-1:0]   sh;
    logic              add;
    logic              pre;
    logic              wb;
    logic              unp;
  } dec_t;
endpackage

// File: rtl/hwl_decode.sv
module hwl_decode
  import hwl_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  form,
  input  logic        cond_pass,
  output dec_t        dec
);
  dec_t d_c32, d_n16, d_w32;

  // conditional 32-bit form
  logic c32_fix, c32_wb;
  always_comb begin
    d_c32     = '0;
    c32_fix   = (word[31:28] != 4'hF) && (word[27:25] == 3'b000) &&
                !word[22] && word[20] && (word[7:4] == 4'b1011);
    c32_wb    = !word[24] || word[21];
    d_c32.rn  = word[19:16];
    d_c32.rt  = word[15:12];
    d_c32.rm  = word[3:0];
    d_c32.pre = word[24];
    d_c32.add = word[23];
    d_c32.wb  = c32_wb;
    if (!c32_fix) begin
      d_c32.res = RES_NOMATCH;
    end else if (!word[24] && word[21]) begin
      d_c32.res = RES_TO_UNPRIV;
    end else begin
      d_c32.unp = (word[15:12] == 4'hF) || (word[3:0] == 4'hF) ||
                  (word[11:8] != 4'h0) ||
                  (c32_wb && ((word[19:16] == 4'hF) || (word[19:16] == word[15:12])));
      if (!cond_pass)
        d_c32.res = RES_SKIP;
      else if (c32_wb && (word[19:16] == word[15:12]))
        d_c32.res = RES_UNDEF;
      else
        d_c32.res = RES_EXEC;
    end
  end

  // 16-bit compact form
  always_comb begin
    d_n16     = '0;
    d_n16.rm  = {1'b0, word[8:6]};
    d_n16.rn  = {1'b0, word[5:3]};
    d_n16.rt  = {1'b0, word[2:0]};
    d_n16.add = 1'b1;
    d_n16.pre = 1'b1;
    if (word[15:9] != 7'b0101101)
      d_n16.res = RES_NOMATCH;
    else if (!cond_pass)
      d_n16.res = RES_SKIP;
    else
      d_n16.res = RES_EXEC;
  end

  // 32-bit compact form
  always_comb begin
    d_w32     = '0;
    d_w32.rn  = word[19:16];
    d_w32.rt  = word[15:12];
    d_w32.rm  = word[3:0];
    d_w32.sh  = word[5:4];
    d_w32.add = 1'b1;
    d_w32.pre = 1'b1;
    if (word[31:20] != 12'b1111_1000_0011) begin
      d_w32.res = RES_NOMATCH;
    end else if (word[19:16] == 4'hF) begin
      d_w32.res = RES_TO_LIT;
    end else if (word[11:6] != 6'd0) begin
      d_w32.res = RES_NOMATCH;
    end else if (word[15:12] == 4'hF) begin
      d_w32.res = RES_TO_PFW;
    end else begin
      d_w32.unp = (word[3:0] == 4'hF);
      d_w32.res = cond_pass ? RES_EXEC : RES_SKIP;
    end
  end

  always_comb begin
    unique case (form)
      FORM_C32: dec = d_c32;
      FORM_N16: dec = d_n16;
      FORM_W32: dec = d_w32;
      default: begin
        dec     = '0;
        dec.res = RES_NOMATCH;
      end
    endcase
  end
endmodule

// File: rtl/hwl_agen.sv
module hwl_agen
  import hwl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offs,
  input  logic [SH_W-1:0] shamt,
  input  logic            add,
  input  logic            pre,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] upd
);
  localparam int N_SH = 1 << SH_W;

  logic [XLEN-1:0] sh_opt [N_SH];
  for (genvar s = 0; s < N_SH; s++) begin : g_sh
    assign sh_opt[s] = offs << s;
  end

  logic [XLEN-1:0] off_sh;
  assign off_sh = sh_opt[shamt];
  assign upd    = add ? (base + off_sh) : (base - off_sh);
  assign ea     = pre ? upd : base;
endmodule

// File: rtl/hwl_seq.sv
module hwl_seq
  import hwl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ins_valid,
  input  logic exec_go,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic ins_ready,
  output logic st_addr,
  output logic req_valid,
  output logic rsp_ready,
  output logic wr_en,
  output logic done
);
  st_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (ins_valid) st_nx = exec_go ? S_ADDR : S_DONE;
      S_ADDR: st_nx = S_REQ;
      S_REQ:  if (req_ready) st_nx = S_WAIT;
      S_WAIT: if (rsp_valid) st_nx = S_WB;
      S_WB:   st_nx = S_DONE;
      S_DONE: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  assign ins_ready = (st == S_IDLE);
  assign st_addr   = (st == S_ADDR);
  assign req_valid = (st == S_REQ);
  assign rsp_ready = (st == S_WAIT);
  assign wr_en     = (st == S_WB);
  assign done      = (st == S_DONE);
endmodule

// File: rtl/hwl_load_unit.sv
module hwl_load_unit
  import hwl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [1:0]        ins_form,
  input  logic [31:0]       ins_word,
  input  logic              ins_cond_pass,
  output logic [RIDX_W-1:0] rf_base_idx,
  input  logic [XLEN-1:0]   rf_base_data,
  output logic [RIDX_W-1:0] rf_offs_idx,
  input  logic [XLEN-1:0]   rf_offs_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [HALF_W-1:0] mem_rsp_data,
  output logic              dst_we,
  output logic [RIDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]   dst_data,
  output logic              base_we,
  output logic [RIDX_W-1:0] base_idx,
  output logic [XLEN-1:0]   base_data,
  output logic              done,
  output logic [2:0]        done_res,
  output logic              done_unp
);
  localparam int PAD_W = XLEN - HALF_W;

  dec_t            dec_now, dec_q;
  logic            exec_go, st_addr, wr_en;
  logic [XLEN-1:0] ea_c, upd_c, ea_q, upd_q;
  logic [HALF_W-1:0] data_q;

  hwl_decode u_dec (
    .word      (ins_word),
    .form      (ins_form),
    .cond_pass (ins_cond_pass),
    .dec       (dec_now)
  );

  assign exec_go = (dec_now.res == RES_EXEC);

  hwl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .exec_go   (exec_go),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .ins_ready (ins_ready),
    .st_addr   (st_addr),
    .req_valid (mem_req_valid),
    .rsp_ready (mem_rsp_ready),
    .wr_en     (wr_en),
    .done      (done)
  );

  hwl_agen #(.XLEN(XLEN)) u_agen (
    .base  (rf_base_data),
    .offs  (rf_offs_data),
    .shamt (dec_q.sh),
    .add   (dec_q.add),
    .pre   (dec_q.pre),
    .ea    (ea_c),
    .upd   (upd_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      ea_q   <= '0;
      upd_q  <= '0;
      data_q <= '0;
    end else begin
      if (ins_valid && ins_ready)        dec_q  <= dec_now;
      if (st_addr) begin
        ea_q  <= ea_c;
        upd_q <= upd_c;
      end
      if (mem_rsp_valid && mem_rsp_ready) data_q <= mem_rsp_data;
    end
  end

  assign rf_base_idx  = dec_q.rn;
  assign rf_offs_idx  = dec_q.rm;
  assign mem_req_addr = ea_q;
  assign dst_we       = wr_en;
  assign dst_idx      = dec_q.rt;
  assign dst_data     = {{PAD_W{1'b0}}, data_q};
  assign base_we      = wr_en && dec_q.wb;
  assign base_idx     = dec_q.rn;
  assign base_data    = upd_q;
  assign done_res     = dec_q.res;
  assign done_unp     = dec_q.unp;
endmodule

// File: rtl/hwl_checker.sv
module hwl_checker
  import hwl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [1:0]        ins_form,
  input logic              ins_cond_pass,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic [HALF_W-1:0] mem_rsp_data,
  input logic              dst_we,
  input logic [RIDX_W-1:0] dst_idx,
  input logic [XLEN-1:0]   dst_data,
  input logic              base_we,
  input logic [RIDX_W-1:0] base_idx,
  input logic              done,
  input logic [2:0]        done_res
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !ins_ready);

  p_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> dst_data[XLEN-1:HALF_W] == '0);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_ready |=> dst_we && dst_data[HALF_W-1:0] == $past(mem_rsp_data));

  p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> dst_we && (base_idx != dst_idx));

  p_done_after_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |=> done && (done_res == RES_EXEC));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready && !ins_cond_pass |=> done && (done_res != RES_EXEC));

  p_rsv_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready && (ins_form == 2'd3) |=> done && (done_res == RES_NOMATCH));
endmodule

bind hwl_load_unit hwl_checker #(.XLEN(XLEN), .HALF_W(HALF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ins_valid     (ins_valid),
  .ins_ready     (ins_ready),
  .ins_form      (ins_form),
  .ins_cond_pass (ins_cond_pass),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .mem_rsp_data  (mem_rsp_data),
  .dst_we        (dst_we),
  .dst_idx       (dst_idx),
  .dst_data      (dst_data),
  .base_we       (base_we),
  .base_idx      (base_idx),
  .done          (done),
  .done_res      (done_res)
);

// File: tb/tb_hwl_load_unit.sv
`timescale 1ns/1ps
module tb_hwl_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0, ins_ready, ins_cond_pass = 1'b1;
  logic [1:0]  ins_form = 2'd0;
  logic [31:0] ins_word = '0;
  logic [3:0]  rf_base_idx, rf_offs_idx, dst_idx, base_idx;
  logic [31:0] rf_base_data, rf_offs_data, mem_req_addr, dst_data, base_data;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [15:0] mem_rsp_data;
  logic        dst_we, base_we, done, done_unp;
  logic [2:0]  done_res;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] rv(input logic [3:0] i);
    return 32'({28'd0, i}) * 32'h1357_9BDF + 32'h0F0F_0F0F;
  endfunction

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[16:1] ^ {a[31:24], a[7:0]} ^ 16'h8421;
  endfunction

  assign rf_base_data = rv(rf_base_idx);
  assign rf_offs_data = rv(rf_offs_idx);

  hwl_load_unit dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_form(ins_form), .ins_word(ins_word), .ins_cond_pass(ins_cond_pass),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
    .rf_offs_idx(rf_offs_idx), .rf_offs_data(rf_offs_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .base_we(base_we), .base_idx(base_idx), .base_data(base_data),
    .done(done), .done_res(done_res), .done_unp(done_unp)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder with varying stalls
  int rq_dly = 0, rs_dly = 0, mseq = 0;
  bit rs_armed = 1'b0;
  logic [31:0] rs_addr = '0;
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        rs_armed = 1'b0;
      end else if (rs_armed) begin
        if (rs_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(rs_addr);
        end else rs_dly--;
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        rs_armed = 1'b1;
        rs_dly = mseq % 3;
        mseq++;
        rq_dly = (mseq * 5) % 4;
      end else if (mem_req_valid) begin
        if (rq_dly == 0) begin
          mem_req_ready = 1'b1;
          rs_addr = mem_req_addr;
        end else rq_dly--;
      end
    end
  end

  // reference model built from the requirements
  function automatic void model(input logic [1:0] f, input logic [31:0] w, input bit cp,
      output int res, output bit unp, output logic [3:0] n, output logic [3:0] t,
      output logic [3:0] m, output int sh, output bit add, output bit pre, output bit wb);
    res = 6; unp = 0; n = 0; t = 0; m = 0; sh = 0; add = 1; pre = 1; wb = 0;
    if (f == 2'd0) begin
      if (w[31:28] != 4'hF && w[27:25] == 3'b000 && !w[22] && w[20] && w[7:4] == 4'hB) begin
        pre = w[24]; add = w[23]; wb = !w[24] || w[21];
        n = w[19:16]; t = w[15:12]; m = w[3:0];
        if (!w[24] && w[21]) res = 2;
        else begin
          unp = (t == 15) || (m == 15) || (w[11:8] != 0) || (wb && (n == 15 || n == t));
          res = !cp ? 1 : ((wb && n == t) ? 5 : 0);
        end
      end
    end else if (f == 2'd1) begin
      if (w[15:9] == 7'b0101101) begin
        m = {1'b0, w[8:6]}; n = {1'b0, w[5:3]}; t = {1'b0, w[2:0]};
        res = cp ? 0 : 1;
      end
    end else if (f == 2'd2) begin
      if (w[31:20] == 12'hF83) begin
        n = w[19:16];
        if (n == 15) res = 3;
        else if (w[11:6] != 0) res = 6;
        else begin
          t = w[15:12];
          if (t == 15) res = 4;
          else begin
            m = w[3:0]; sh = int'(w[5:4]); unp = (m == 15);
            res = cp ? 0 : 1;
          end
        end
      end
    end
  endfunction

  task automatic run(input logic [1:0] f, input logic [31:0] w, input bit cp);
    int res, sh, cyc, dcyc, wcyc, nhs;
    bit unp, add, pre, wb, seen, dseen, bseen, stall;
    logic [3:0] n, t, m, didx, bidx;
    logic [31:0] off, upd, ea, ddat, bdat, raddr, paddr;
    string rtag;
    model(f, w, cp, res, unp, n, t, m, sh, add, pre, wb);
    off = rv(m) << sh;
    upd = add ? rv(n) + off : rv(n) - off;
    ea  = pre ? upd : rv(n);
    @(negedge clk);
    ins_form = f; ins_word = w; ins_cond_pass = cp; ins_valid = 1'b1;
    #1;
    while (!ins_ready) begin @(negedge clk); #1; end
    cyc = 0; dcyc = 0; wcyc = 0; nhs = 0; seen = 0; dseen = 0; bseen = 0; stall = 0;
    raddr = '0; paddr = '0; didx = '0; bidx = '0; ddat = '0; bdat = '0;
    while (!seen && cyc < 60) begin
      @(negedge clk);
      ins_valid = 1'b0;
      #1;
      cyc++;
      if (!ins_ready) ; else chk(0, "R12 ready while busy", 1, 0);
      if (mem_req_valid) begin
        if (stall) chk(mem_req_addr == paddr, "R12 address hold", mem_req_addr, paddr);
        stall = !mem_req_ready;
        paddr = mem_req_addr;
        if (mem_req_ready) begin nhs++; raddr = mem_req_addr; end
      end else if (stall) begin
        chk(0, "R12 valid dropped", 0, 1);
        stall = 0;
      end
      if (dst_we) begin dseen = 1; wcyc = cyc; didx = dst_idx; ddat = dst_data; end
      if (base_we) begin bseen = 1; bidx = base_idx; bdat = base_data; end
      if (done) begin seen = 1; dcyc = cyc; end
    end
    case (res)
      0: rtag = (f == 2'd0) ? "R2" : (f == 2'd1) ? "R4" : "R5";
      1: rtag = "R11";
      2: rtag = "R3";
      3, 4: rtag = "R5";
      5: rtag = "R10";
      default: rtag = "R1";
    endcase
    chk(seen, {rtag, " done seen"}, 32'(seen), 1);
    if (!seen) return;
    chk(done_res == 3'(res), {rtag, " outcome"}, 32'(done_res), 32'(res));
    if (res == 0 || res == 1 || res == 5)
      chk(done_unp == unp, "R9 unpredictable flag", 32'(done_unp), 32'(unp));
    if (res == 0) begin
      chk(nhs == 1, "R12 one request", 32'(nhs), 1);
      chk(raddr == ea, "R6 address", raddr, ea);
      chk(dseen && didx == t, {rtag, " dst index"}, 32'(didx), 32'(t));
      chk(ddat == {16'h0, memf(ea)}, "R7 zero-extended data", ddat, {16'h0, memf(ea)});
      chk(dcyc == wcyc + 1, "R13 done after write", 32'(dcyc), 32'(wcyc + 1));
      if (wb) begin
        chk(bseen && bidx == n, "R8 base index", 32'(bidx), 32'(n));
        chk(bdat == upd, "R8 base value", bdat, upd);
      end else
        chk(!bseen, (f == 2'd1) ? "R4 no writeback" : "R8 no writeback", 32'(bseen), 0);
    end else begin
      chk(dcyc == 1, {rtag, " one-cycle completion"}, 32'(dcyc), 1);
      chk(nhs == 0 && !dseen && !bseen, {rtag, " no access or write"},
          32'(nhs) + 32'(dseen) + 32'(bseen), 0);
    end
    @(negedge clk);
    chk(!done, "R13 done pulse width", 32'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ins_ready == 1'b0 || 1'b1, "R12 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ins_ready == 1'b1, "R12 idle after reset", 32'(ins_ready), 1);
    chk(!done && !mem_req_valid && !dst_we && !base_we, "R13 quiet after reset",
        32'(done) + 32'(mem_req_valid) + 32'(dst_we), 0);

    // conditional form sweep: P,U,W x base x index, destination varied
    for (int puw = 0; puw < 8; puw++)
      for (int n = 0; n < 16; n++)
        for (int m = 0; m < 16; m++)
          for (int k = 0; k < 2; k++) begin
            logic [3:0] t = (k == 0) ? 4'((n + m + 1) % 16) : 4'(n);
            logic [3:0] cnd = 4'((n + m) % 15);
            logic [3:0] sbz = ((n * 16 + m) % 97 == 0) ? 4'h2 : 4'h0;
            run(2'd0, {cnd, 3'b000, puw[2], puw[1], 1'b0, puw[0], 1'b1, 4'(n), t,
                       sbz, 4'b1011, 4'(m)}, 1'b1);
          end

    // conditional form: condition fails, reserved cond, broken fixed bits
    run(2'd0, {4'h1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, 4'h0, 4'b1011, 4'd4}, 1'b0);
    run(2'd0, {4'h1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 4'd5, 4'h0, 4'b1011, 4'd4}, 1'b0);
    run(2'd0, {4'hF, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, 4'h0, 4'b1011, 4'd4}, 1'b1);
    run(2'd0, {4'hE, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 4'd3, 4'h0, 4'b1011, 4'd4}, 1'b1);
    run(2'd0, {4'hE, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd3, 4'h0, 4'b1011, 4'd4}, 1'b1);
    run(2'd0, {4'hE, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, 4'h0, 4'b1011, 4'd4}, 1'b1);
    run(2'd0, {4'hE, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, 4'h0, 4'b1101, 4'd4}, 1'b1);

    // 16-bit compact form: every register triple, upper half ignored
    for (int i = 0; i < 512; i++)
      run(2'd1, {16'hBEEF, 7'b0101101, 9'(i)}, (i % 7) != 0);
    run(2'd1, {16'h0000, 7'b0101100, 9'd77}, 1'b1);

    // 32-bit compact form: base x destination x shift, index varied
    for (int n = 0; n < 16; n++)
      for (int t = 0; t < 16; t++)
        for (int s = 0; s < 4; s++) begin
          logic [3:0] m = ((n + t + s) % 5 == 0) ? 4'hF : 4'((n * 3 + t + s) % 16);
          run(2'd2, {12'hF83, 4'(n), 4'(t), 6'd0, 2'(s), m}, ((n + t) % 9) != 0);
        end
    run(2'd2, {12'hF83, 4'd3, 4'd4, 6'b000100, 2'd1, 4'd5}, 1'b1);
    run(2'd2, {12'hF83, 4'hF, 4'd4, 6'b010101, 2'd1, 4'd5}, 1'b1);
    run(2'd2, {12'hF93, 4'd3, 4'd4, 6'd0, 2'd1, 4'd5}, 1'b1);

    // reserved form select
    run(2'd3, {12'hF83, 4'd3, 4'd4, 6'd0, 2'd1, 4'd5}, 1'b1);
    run(2'd3, 32'h0000_5A00, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule